// File: doc/BRIEF.md
# Vector Beam Pattern Player

This peripheral keeps a short list of two-axis sample points and replays them in a loop to steer a beam. Software reaches it over a 16-bit register bus with an address, write data, read data and separate write and read strobes. Four word addresses starting at a base address hold a control word, a step-interval word, and one load port for each axis.

To program a figure, software first sets the load flag in the control word, which rewinds both load pointers. It then writes the X points and the Y points through their load ports. A second control write clears the load flag, sets the play flag and gives the point count. While playing, the block walks the stored points at the programmed interval and drives signed 16-bit X and Y samples. Each point is either held for the whole interval or, with the ramp flag set, reached by a straight line from the previous point.

Top module: `vbeam_player`

## Requirements
- R1: After reset the control word, the interval word, `bus_rdata`, `x_out` and `y_out` are all zero.
- R2: The control word is at BASE_ADDR+0, the interval word at BASE_ADDR+1, the X load port at BASE_ADDR+2 and the Y load port at BASE_ADDR+3 (BASE_ADDR defaults to 0x20). A read strobe loads `bus_rdata` at the next clock edge. Reading the control word gives back all 16 bits last written, and reading the interval word gives back its value. The load ports and all other addresses read as zero, and `bus_rdata` holds its value when no read strobe is present.
- R3: Control bit 1 is the load flag. Any control write with bit 1 set rewinds both load pointers to entry 0. While the flag is set, each write to an axis load port stores the signed value at that axis's pointer and then advances the pointer. The pointer wraps from DEPTH-1 to 0, so write DEPTH+1 lands on entry 0.
- R4: Writes to a load port while the load flag is clear leave the point memory and the pointers unchanged.
- R5: Control bit 0 is the play flag. One clock edge after the flag reads clear, `x_out` and `y_out` are zero, and playback restarts from entry 0 with a fresh interval.
- R6: The step interval P is the interval word, or 1 when that word is 0. The play index advances once every P clocks.
- R7: The point count sits in control bits [10:7], so a count of N is written as N*0x80. The play index runs from 0 to L-1 and then returns to 0, where L is the count, except that a count of 0 gives L=1 and a count above DEPTH gives L=DEPTH.
- R8: Control bit 2 is the ramp flag. With the flag clear, the output on the clock edge j+1 after play is set is the point at index (j/P) mod L.
- R9: With the ramp flag set, that output is c + ((n - c)*k)/P. Here c is the point at index (j/P) mod L, n is the point at the following index (wrapping to index 0), k = j mod P, and the division truncates toward zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | DATA_W | Read data, registered |
| x_out | output | DATA_W | Signed X sample |
| y_out | output | DATA_W | Signed Y sample |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data appears one edge after the read strobe, and the bench reads it at the falling edge that follows. The outputs lag the play state by one register: the first point appears on the edge after the control write that sets play, and zero appears on the edge after play is cleared. The bench therefore numbers the samples j = 0, 1, ... starting at the first falling edge after that control write, and computes each expected point from j, P and L. Sweeps cover several intervals, counts and both output modes, and each sweep runs two full laps so that the wrap from L-1 to 0 is checked.

// File: rtl/vbeam_player.sv
module vbeam_player #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SPEED_W = 16,
  parameter int DEPTH = 8,
  parameter int SIZE_LSB = 7,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] y_out
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int SIZE_W = PTR_W + 1;
  localparam int PROD_W = DATA_W + SPEED_W + 3;

  logic [DATA_W-1:0] ctrl_q;
  logic [SPEED_W-1:0] speed_q;
  logic [PTR_W-1:0] wp_x, wp_y, rd_ptr, nxt_ptr;
  logic [SPEED_W-1:0] tick_cnt, period;
  logic [SIZE_W-1:0] size_f, len;
  logic [DATA_W-1:0] mem_x [DEPTH];
  logic [DATA_W-1:0] mem_y [DEPTH];
  logic sel_ctrl, sel_speed, sel_x, sel_y;
  logic run, upd, lin, last_step;

  assign sel_ctrl  = bus_addr == BASE_ADDR;
  assign sel_speed = bus_addr == BASE_ADDR + ADDR_W'(1);
  assign sel_x     = bus_addr == BASE_ADDR + ADDR_W'(2);
  assign sel_y     = bus_addr == BASE_ADDR + ADDR_W'(3);

  assign run    = ctrl_q[0];
  assign upd    = ctrl_q[1];
  assign lin    = ctrl_q[2];
  assign size_f = ctrl_q[SIZE_LSB +: SIZE_W];
  assign len    = (size_f == '0) ? SIZE_W'(1) :
                  (size_f > SIZE_W'(DEPTH)) ? SIZE_W'(DEPTH) : size_f;
  assign period = (speed_q == '0) ? SPEED_W'(1) : speed_q;
  assign last_step = tick_cnt >= period - SPEED_W'(1);
  assign nxt_ptr = ({1'b0, rd_ptr} >= len - SIZE_W'(1)) ? '0 : rd_ptr + PTR_W'(1);

  function automatic logic [DATA_W-1:0] ramp(
    input logic signed [DATA_W-1:0] a,
    input logic signed [DATA_W-1:0] b,
    input logic [SPEED_W-1:0] k,
    input logic [SPEED_W-1:0] p
  );
    logic signed [DATA_W+1:0] d;
    logic signed [PROD_W-1:0] prod, q, s;
    d = {{2{b[DATA_W-1]}}, b} - {{2{a[DATA_W-1]}}, a};
    prod = PROD_W'(d) * $signed({1'b0, k});
    q = prod / $signed(PROD_W'({1'b0, p}));
    s = PROD_W'(a) + q;
    return s[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      speed_q <= '0;
      wp_x    <= '0;
      wp_y    <= '0;
    end else if (bus_we) begin
      if (sel_ctrl) begin
        ctrl_q <= bus_wdata;
        if (bus_wdata[1]) begin
          wp_x <= '0;
          wp_y <= '0;
        end
      end
      if (sel_speed) speed_q <= bus_wdata[SPEED_W-1:0];
      if (sel_x && upd) wp_x <= wp_x + PTR_W'(1);
      if (sel_y && upd) wp_y <= wp_y + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (bus_we && upd && sel_x) mem_x[wp_x] <= bus_wdata;
    if (bus_we && upd && sel_y) mem_y[wp_y] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re)
      bus_rdata <= sel_ctrl ? ctrl_q : sel_speed ? DATA_W'(speed_q) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      x_out    <= '0;
      y_out    <= '0;
      rd_ptr   <= '0;
      tick_cnt <= '0;
    end else begin
      x_out <= lin ? ramp(mem_x[rd_ptr], mem_x[nxt_ptr], tick_cnt, period) : mem_x[rd_ptr];
      y_out <= lin ? ramp(mem_y[rd_ptr], mem_y[nxt_ptr], tick_cnt, period) : mem_y[rd_ptr];
      if (last_step) begin
        tick_cnt <= '0;
        rd_ptr   <= nxt_ptr;
      end else begin
        tick_cnt <= tick_cnt + SPEED_W'(1);
      end
    end
  end
endmodule

// File: rtl/vbeam_player_chk.sv
module vbeam_player_chk #(
  parameter int DATA_W = 16,
  parameter int SPEED_W = 16,
  parameter int PTR_W = 3,
  parameter int SIZE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic              sel_ctrl,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [PTR_W-1:0]  wp_x,
  input logic [PTR_W-1:0]  wp_y,
  input logic [PTR_W-1:0]  rd_ptr,
  input logic [SPEED_W-1:0] tick_cnt,
  input logic [SPEED_W-1:0] period,
  input logic [SIZE_W-1:0] len,
  input logic [DATA_W-1:0] x_out,
  input logic [DATA_W-1:0] y_out
);
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

  p_wptr_rewind_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel_ctrl && bus_wdata[1]) |=> (wp_x == '0 && wp_y == '0));

  p_load_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[1] && !(bus_we && sel_ctrl)) |=> ($stable(wp_x) && $stable(wp_y)));

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[0] |=> (x_out == '0 && y_out == '0 && rd_ptr == '0 && tick_cnt == '0));

  p_step_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[0] && tick_cnt < period - SPEED_W'(1)) |=> $stable(rd_ptr));

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[0] && tick_cnt >= period - SPEED_W'(1) && {1'b0, rd_ptr} >= len - SIZE_W'(1))
      |=> rd_ptr == '0);
endmodule

bind vbeam_player vbeam_player_chk #(
  .DATA_W(DATA_W), .SPEED_W(SPEED_W), .PTR_W(PTR_W), .SIZE_W(SIZE_W)
) chk_i (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .sel_ctrl(sel_ctrl),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_q(ctrl_q),
  .wp_x(wp_x), .wp_y(wp_y), .rd_ptr(rd_ptr), .tick_cnt(tick_cnt),
  .period(period), .len(len), .x_out(x_out), .y_out(y_out)
);

// File: tb/vbeam_player_tb.sv
module vbeam_player_tb_top;
  localparam int DEPTH = 8;
  localparam int BASE = 'h20;
  localparam int A_CTRL = BASE, A_SPD = BASE + 1, A_X = BASE + 2, A_Y = BASE + 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [15:0] bus_rdata, x_out, y_out;

  int n_chk = 0, n_fail = 0;
  int mx[DEPTH], my[DEPTH];
  int wpx = 0, wpy = 0, bctrl = 0;

  always #2.5 clk = ~clk;

  vbeam_player dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .x_out(x_out), .y_out(y_out)
  );

  function automatic int sx(int v);
    return (v & 'h8000) ? (v & 'hFFFF) - 'h10000 : (v & 'hFFFF);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    bus_addr = 8'(addr); bus_wdata = 16'(data); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    if (addr == A_CTRL) begin
      bctrl = data & 'hFFFF;
      if (data & 2) begin wpx = 0; wpy = 0; end
    end else if (addr == A_X && (bctrl & 2)) begin
      mx[wpx] = sx(data); wpx = (wpx + 1) % DEPTH;
    end else if (addr == A_Y && (bctrl & 2)) begin
      my[wpy] = sx(data); wpy = (wpy + 1) % DEPTH;
    end
  endtask

  task automatic rd(int addr, output int v);
    @(negedge clk);
    bus_addr = 8'(addr); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    v = int'(bus_rdata);
  endtask

  function automatic int expect_pt(bit ax, int j, int len, int p, int lin);
    int idx, k, c, n;
    idx = (j / p) % len;
    k = j % p;
    c = ax ? my[idx] : mx[idx];
    n = ax ? my[(idx + 1) % len] : mx[(idx + 1) % len];
    return lin ? c + ((n - c) * k) / p : c;
  endfunction

  task automatic run_cfg(string tag, int spd, int sz, int lin);
    int len, p, v;
    wr(A_CTRL, 0);
    @(negedge clk);
    chk("R5 x idle", int'($signed(x_out)), 0);
    chk("R5 y idle", int'($signed(y_out)), 0);
    wr(A_SPD, spd);
    wr(A_CTRL, 1 | (lin << 2) | (sz << 7));
    len = (sz == 0) ? 1 : (sz > DEPTH) ? DEPTH : sz;
    p = (spd == 0) ? 1 : spd;
    for (int j = 0; j < 2 * len * p + 3; j++) begin
      @(negedge clk);
      chk({tag, " x"}, int'($signed(x_out)), expect_pt(1'b0, j, len, p, lin));
      chk({tag, " y"}, int'($signed(y_out)), expect_pt(1'b1, j, len, p, lin));
    end
    rd(A_CTRL, v);
    chk("R2 ctrl readback while playing", v, bctrl);
  endtask

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    for (int i = 0; i < DEPTH; i++) begin mx[i] = 0; my[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 rdata", int'(bus_rdata), 0);
    chk("R1 x", int'(x_out), 0);
    chk("R1 y", int'(y_out), 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_SPD, v);  chk("R1 speed", v, 0);

    wr(A_SPD, 3);
    rd(A_SPD, v);  chk("R2 speed readback", v, 3);
    rd(A_X, v);    chk("R2 x port reads zero", v, 0);
    rd(A_Y, v);    chk("R2 y port reads zero", v, 0);
    rd(0, v);      chk("R2 unmapped reads zero", v, 0);
    wr(A_CTRL, 'hFF82);
    rd(A_CTRL, v); chk("R2 ctrl full readback", v, 'hFF82);

    // R3: load a full set of points per axis
    for (int i = 0; i < DEPTH; i++) begin
      wr(A_X, (i * 9001 + 'hC000) & 'hFFFF);
      wr(A_Y, ('h7000 - i * 7777) & 'hFFFF);
    end
    // R4: load writes with the load flag clear are dropped
    wr(A_CTRL, 0);
    wr(A_X, 'h1234);
    wr(A_Y, 'h4321);

    run_cfg("R8 hold", 3, 4, 0);
    run_cfg("R9 ramp", 3, 4, 1);
    run_cfg("R4 R8 full", 1, 8, 0);
    run_cfg("R6 zero interval", 0, 3, 0);
    run_cfg("R7 count zero", 5, 0, 0);
    run_cfg("R7 count clamp", 4, 15, 1);
    run_cfg("R9 ramp two", 7, 2, 1);
    run_cfg("R9 ramp full", 2, 8, 1);

    // R3: pointer rewind and wrap
    wr(A_CTRL, 2);
    for (int i = 0; i < DEPTH + 1; i++) wr(A_X, ('h7000 - i * 3000) & 'hFFFF);
    wr(A_Y, 'hC000);
    run_cfg("R3 wrap hold", 1, 8, 0);
    run_cfg("R3 wrap ramp", 3, 8, 1);

    wr(A_CTRL, 0);
    @(negedge clk);
    chk("R5 final x", int'($signed(x_out)), 0);
    chk("R5 final y", int'($signed(y_out)), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule